// File: doc/BRIEF.md
# Pulse-Interval Frame Receiver with Reply Timer

This block receives frames that a reader sends by briefly dropping its field. Every drop ends in a rising edge of the field-present signal. The data lies in the time between successive rising edges. A free-running counter measures that time in carrier periods. A carrier period is 8 µs. The parameter `CLKS_PER_UNIT` sets how many system clocks make one period.

Each rising edge closes an interval, and the block sorts that interval into one of four kinds:
- a data 0,
- a data 1,
- a long start or gap marker,
- noise that is too short to mean anything.

Data bits are packed into a bit vector, first bit received in the most significant position. When the field has stayed quiet for long enough, the frame is declared complete. The block then starts timing the tag's answer and raises a one-cycle "transmit now" strobe at the moment the answer must begin.

The field input is asynchronous and is synchronised inside the block. Both the analog field detector and the load-modulation driver sit outside it.

Top module: `pir_frame_rx`

## Requirements
- R1: After reset, `frame_valid` and `tx_now` are low, and `frame_len` and `frame_data` are zero.
- R2: An interval of 36 units or more between rising edges is a start or gap marker. It adds no bit to the frame.
- R3: An interval of at least 25 and below 36 units appends a 1.
- R4: An interval of at least 15 and below 25 units appends a 0. `frame_len` counts the appended bits.
- R5: An interval below 15 units adds no bit. The interval measurement restarts at that edge.
- R6: When 80 units pass after the last rising edge, `frame_valid` pulses for exactly one cycle. This happens only if the frame holds at least one bit.
- R7: The bit received n-th (counting from 0) sits at `frame_data[159-n]`. Positions not yet written read 0.
- R8: A frame keeps at most 160 bits (20 bytes). Further bits are dropped, and `frame_len` stays at 160.
- R9: `tx_now` pulses for one cycle 192 units after the last rising edge of a valid frame. That is exactly 112 units after the `frame_valid` pulse, and it occurs only after such a frame.
- R10: A rising edge that arrives after `frame_valid` but before `tx_now` cancels the pending `tx_now`.
- R11: The interval counter saturates during long idle time instead of wrapping. After any idle time, the next edge is still a start marker.
- R12: `frame_len` and `frame_data` hold their values after a frame until the first data bit of the next frame. Markers and noise edges leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_in | input | 1 | Asynchronous field-present level; a rising edge ends a field drop |
| frame_data | output | MAX_BYTES*8 (160) | Received bits, first bit in the top position |
| frame_len | output | clog2(MAX_BYTES*8+1) (8) | Number of bits received |
| frame_valid | output | 1 | One-cycle strobe: the frame is complete |
| tx_now | output | 1 | One-cycle strobe: the reply must start |

## Verification
The assertions assume that `field_in` is steady across several clocks, so that each rising edge is seen exactly once after synchronisation. They also assume that drops and gaps last whole carrier units or more. The stimulus keeps to this by driving the field only on falling clock edges, with 6-unit drops and gaps of many clocks.

The assertions also rely on the interval being the only timebase. The bench therefore places every edge at a half-unit offset from the decision thresholds, so each interval falls unambiguously into one class. Noise edges are still spaced by several units, so synchronisation never merges two of them.

// File: rtl/pir_pkg.sv
package pir_pkg;

  typedef enum logic [1:0] {
    SYM_NOISE = 2'd0,
    SYM_ZERO  = 2'd1,
    SYM_ONE   = 2'd2,
    SYM_MARK  = 2'd3
  } sym_e;

  // Sort an interval (in carrier units) into a symbol class.
  function automatic sym_e classify(input logic [31:0] ivl,
                                    input int unsigned zero_min,
                                    input int unsigned one_min,
                                    input int unsigned mark_min);
    if (ivl >= mark_min)      return SYM_MARK;
    else if (ivl >= one_min)  return SYM_ONE;
    else if (ivl >= zero_min) return SYM_ZERO;
    else                      return SYM_NOISE;
  endfunction

  function automatic logic is_data(input sym_e s);
    return (s == SYM_ZERO) || (s == SYM_ONE);
  endfunction

endpackage

// File: rtl/pir_edge_sync.sv
module pir_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/pir_unit_timer.sv
module pir_unit_timer #(
  parameter int CLKS_PER_UNIT = 384,
  parameter int IVL_W         = 9,
  parameter int EOF_UNITS     = 80,
  parameter int REPLY_AT      = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [IVL_W-1:0] ivl,
  output logic             eof_hit,
  output logic             reply_hit
);
  localparam int DIV_W = $clog2(CLKS_PER_UNIT + 1);
  localparam logic [IVL_W-1:0] IVL_MAX = {IVL_W{1'b1}};

  logic [DIV_W-1:0] div;
  logic             tick;

  assign tick = (div == DIV_W'(CLKS_PER_UNIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0;
      ivl <= '0;
    end else if (restart) begin
      div <= '0;
      ivl <= '0;
    end else if (tick) begin
      div <= '0;
      if (ivl != IVL_MAX) ivl <= ivl + IVL_W'(1);
    end else begin
      div <= div + DIV_W'(1);
    end
  end

  assign eof_hit   = tick & ~restart & (ivl == IVL_W'(EOF_UNITS - 1));
  assign reply_hit = tick & ~restart & (ivl == IVL_W'(REPLY_AT - 1));
endmodule

// File: rtl/pir_bit_packer.sv
module pir_bit_packer #(
  parameter int MAX_BITS = 160,
  parameter int LEN_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                bit_val,
  input  logic                close,
  output logic [MAX_BITS-1:0] data,
  output logic [LEN_W-1:0]    len,
  output logic                open
);
  logic [LEN_W-1:0] pos;

  assign pos = LEN_W'(MAX_BITS - 1) - len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      len  <= '0;
      open <= 1'b0;
    end else if (close) begin
      open <= 1'b0;
    end else if (bit_en) begin
      if (!open) begin
        open               <= 1'b1;
        data               <= '0;
        data[MAX_BITS-1]   <= bit_val;
        len                <= LEN_W'(1);
      end else if (len < LEN_W'(MAX_BITS)) begin
        data[pos] <= bit_val;
        len       <= len + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/pir_reply_ctrl.sv
module pir_reply_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic eof_hit,
  input  logic reply_hit,
  input  logic open,
  output logic frame_valid,
  output logic tx_now,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      tx_now      <= 1'b0;
      armed       <= 1'b0;
    end else begin
      frame_valid <= eof_hit & open;
      tx_now      <= reply_hit & armed;
      if (rise)                armed <= 1'b0;
      else if (eof_hit & open) armed <= 1'b1;
      else if (reply_hit)      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pir_frame_rx.sv
module pir_frame_rx #(
  parameter int CLKS_PER_UNIT = 384,
  parameter int SYNC_STAGES   = 2,
  parameter int ZERO_MIN      = 15,
  parameter int ONE_MIN       = 25,
  parameter int MARK_MIN      = 36,
  parameter int EOF_UNITS     = 80,
  parameter int REPLY_WAIT    = 200,
  parameter int LOW_UNITS     = 8,
  parameter int MAX_BYTES     = 20,
  localparam int MAX_BITS     = MAX_BYTES * 8,
  localparam int LEN_W        = $clog2(MAX_BITS + 1),
  localparam int REPLY_AT     = REPLY_WAIT - LOW_UNITS,
  localparam int IVL_W        = $clog2(REPLY_AT + 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                field_in,
  output logic [MAX_BITS-1:0] frame_data,
  output logic [LEN_W-1:0]    frame_len,
  output logic                frame_valid,
  output logic                tx_now
);
  import pir_pkg::*;

  logic             rise;
  logic [IVL_W-1:0] ivl;
  logic             eof_hit;
  logic             reply_hit;
  logic             open;
  logic             armed;
  sym_e             sym;
  logic             bit_en;

  pir_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(field_in), .rise(rise)
  );

  pir_unit_timer #(
    .CLKS_PER_UNIT(CLKS_PER_UNIT), .IVL_W(IVL_W),
    .EOF_UNITS(EOF_UNITS), .REPLY_AT(REPLY_AT)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(rise), .ivl(ivl),
    .eof_hit(eof_hit), .reply_hit(reply_hit)
  );

  assign sym    = classify(32'(ivl), ZERO_MIN, ONE_MIN, MARK_MIN);
  assign bit_en = rise & is_data(sym);

  pir_bit_packer #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_val(sym == SYM_ONE),
    .close(eof_hit), .data(frame_data), .len(frame_len), .open(open)
  );

  pir_reply_ctrl u_reply (
    .clk(clk), .rst_n(rst_n), .rise(rise), .eof_hit(eof_hit),
    .reply_hit(reply_hit), .open(open), .frame_valid(frame_valid),
    .tx_now(tx_now), .armed(armed)
  );
endmodule

// File: rtl/pir_frame_rx_chk.sv
module pir_frame_rx_chk #(
  parameter int IVL_W     = 9,
  parameter int LEN_W     = 8,
  parameter int MAX_BITS  = 160,
  parameter int EOF_UNITS = 80,
  parameter int REPLY_AT  = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic [IVL_W-1:0] ivl,
  input pir_pkg::sym_e    sym,
  input logic             open,
  input logic             armed,
  input logic [LEN_W-1:0] frame_len,
  input logic             frame_valid,
  input logic             tx_now
);
  import pir_pkg::*;
  localparam logic [IVL_W-1:0] IVL_MAX = {IVL_W{1'b1}};

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  a_r6_valid_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (ivl == IVL_W'(EOF_UNITS)) && (frame_len != '0));
  a_r9_tx_at_reply: assert property (@(posedge clk) disable iff (!rst_n)
    tx_now |-> ivl == IVL_W'(REPLY_AT));
  a_r9_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_now |=> !tx_now);
  a_r5_noise_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sym == SYM_NOISE) |=> $stable(frame_len));
  a_r2_mark_keeps_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sym == SYM_MARK) |=> $stable(frame_len));
  a_r3_bit_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (sym == SYM_ONE || sym == SYM_ZERO) && open && frame_len < LEN_W'(MAX_BITS))
      |=> frame_len == $past(frame_len) + LEN_W'(1));
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= LEN_W'(MAX_BITS));
  a_r10_rise_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !armed);
  a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl == IVL_MAX && !rise) |=> ivl == IVL_MAX);
endmodule

bind pir_frame_rx pir_frame_rx_chk #(
  .IVL_W(IVL_W), .LEN_W(LEN_W), .MAX_BITS(MAX_BITS),
  .EOF_UNITS(EOF_UNITS), .REPLY_AT(REPLY_AT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .ivl(ivl), .sym(sym),
  .open(open), .armed(armed), .frame_len(frame_len),
  .frame_valid(frame_valid), .tx_now(tx_now)
);

// File: tb/sim_pir_frame_rx.sv
module sim_pir_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int C          = 4;
  localparam int NB         = 160;
  localparam int EOF_U      = 80;
  localparam int REPLY_U    = 192;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            field_in = 1'b1;
  logic [NB-1:0]   frame_data;
  logic [7:0]      frame_len;
  logic            frame_valid;
  logic            tx_now;

  pir_frame_rx #(.CLKS_PER_UNIT(C)) u0 (
    .clk(clk), .rst_n(rst_n), .field_in(field_in), .frame_data(frame_data),
    .frame_len(frame_len), .frame_valid(frame_valid), .tx_now(tx_now)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int len; logic [NB-1:0] data; bit tx; } exp_t;
  exp_t sb[$];
  exp_t e;
  int   gq[$];
  int   n_chk = 0, n_fail = 0;
  int   last_rise_cyc = 0, valid_cyc = 0;
  bit   tx_pending = 0;

  task automatic chk(bit ok, string req, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_half(int h);
    repeat (h * C / 2) @(negedge clk);
  endtask

  // 6-unit field drop; its end is the rising edge
  task automatic drop();
    field_in = 1'b0;
    hold_half(12);
    field_in = 1'b1;
    last_rise_cyc = cyc;
  endtask

  // next rising edge h half-units after the previous one
  task automatic gap(int h);
    hold_half(h - 12);
    drop();
  endtask

  // spacing of h half-units is seen as (h-1)/2 whole units
  task automatic run_frame(bit exp_tx);
    exp_t x;
    x.len = 0; x.data = '0; x.tx = exp_tx;
    foreach (gq[i]) begin
      int u = (gq[i] - 1) / 2;
      if (u < 36 && u >= 15) begin
        if (x.len < NB) begin
          x.data[NB-1-x.len] = (u >= 25);
          x.len++;
        end
      end
    end
    if (x.len > 0) sb.push_back(x);
    drop();
    foreach (gq[i]) gap(gq[i]);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R6", "unexpected frame_valid", frame_len, 0);
        end else begin
          e = sb.pop_front();
          chk(frame_len == e.len, "R4", "frame length", frame_len, e.len);
          chk(frame_data == e.data, "R7", "frame data", frame_data, e.data);
          chk((cyc - last_rise_cyc >= EOF_U*C) && (cyc - last_rise_cyc <= EOF_U*C + 6),
              "R6", "end-of-frame latency", cyc - last_rise_cyc, EOF_U*C);
          if (tx_pending) chk(0, "R9", "tx_now missing before next frame", 0, 1);
          tx_pending = e.tx;
          valid_cyc  = cyc;
        end
      end
      if (tx_now) begin
        chk(tx_pending, "R10", "tx_now without pending reply", 1, tx_pending);
        chk(cyc - valid_cyc == (REPLY_U - EOF_U) * C, "R9", "reply delay",
            cyc - valid_cyc, (REPLY_U - EOF_U) * C);
        tx_pending = 0;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  initial begin
    logic [NB-1:0] keep_d;
    logic [7:0]    keep_l;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(frame_valid == 0, "R1", "frame_valid after reset", frame_valid, 0);
    chk(tx_now == 0, "R1", "tx_now after reset", tx_now, 0);
    chk(frame_len == 0, "R1", "frame_len after reset", frame_len, 0);
    chk(frame_data == 0, "R1", "frame_data after reset", frame_data, 0);
    hold_half(200);

    // bits 11000 with nominal 28/22-unit bit times
    gq = {56, 56, 44, 44, 44};
    run_frame(1);
    hold_half(500);
    chk(frame_data[NB-1 -: 5] == 5'b11000, "R3", "ones and zeros decoded", frame_data[NB-1 -: 5], 5'b11000);
    chk(frame_data[NB-6:0] == 0, "R7", "unwritten bits zero", frame_data[NB-6:0], 0);

    // 16-bit pattern
    gq = {};
    for (int i = 0; i < 16; i++) gq.push_back(((16'hA5C3 >> (15 - i)) & 1) != 0 ? 56 : 44);
    run_frame(1);
    hold_half(500);
    chk(frame_data[NB-1 -: 16] == 16'hA5C3, "R7", "MSB-first packing", frame_data[NB-1 -: 16], 16'hA5C3);

    // thresholds: 15.5,24.5->0  25.5,35.5->1  36.5 mark  22->0  14.5 noise  22.5->0  28->1
    gq = {31, 49, 51, 71, 73, 44, 29, 45, 56};
    run_frame(1);
    hold_half(500);
    chk(frame_len == 7, "R2", "marker adds no bit", frame_len, 7);
    chk(frame_data[NB-1 -: 7] == 7'b0011001, "R5", "noise ignored, interval restarted",
        frame_data[NB-1 -: 7], 7'b0011001);

    // overlong frame
    gq = {};
    for (int i = 0; i < 170; i++) gq.push_back((i % 3 == 0) ? 56 : 44);
    run_frame(1);
    hold_half(500);
    chk(frame_len == NB, "R8", "length capped", frame_len, NB);

    // new frame starts 100 units after the last edge: reply cancelled
    gq = {56, 44, 56};
    run_frame(0);
    hold_half(200);
    gq = {44, 44};
    run_frame(1);
    hold_half(500);
    chk(frame_data[NB-1 -: 2] == 2'b00, "R10", "second frame after cancel", frame_data[NB-1 -: 2], 0);

    // long idle, lone marker, noise: no frame, results held
    keep_d = frame_data; keep_l = frame_len;
    hold_half(1200);
    drop();
    hold_half(300);
    chk(frame_len == keep_l && frame_data == keep_d, "R12", "held after lone marker", frame_len, keep_l);
    drop();
    gap(24);
    hold_half(400);
    chk(frame_len == keep_l && frame_data == keep_d, "R12", "held after noise edge", frame_len, keep_l);
    chk(frame_valid == 0 && tx_now == 0, "R6", "no strobe without data", frame_valid, 0);
    hold_half(1200);
    gq = {56};
    run_frame(1);
    hold_half(600);
    chk(frame_len == 1 && frame_data[NB-1] == 1'b1, "R11", "decode after saturated idle", frame_len, 1);

    chk(sb.size() == 0, "R6", "all expected frames seen", sb.size(), 0);
    chk(!tx_pending, "R9", "last reply delivered", tx_pending, 0);
    finish_run();
  end
endmodule